// File: doc/BRIEF.md
# Accumulator Adder/Subtractor with Flag Register

This block is the arithmetic stage that sits between an accumulator and a second operand register. From the two operand values and a subtract strobe it forms either their sum or their difference with one shared ripple-carry adder. For the difference, the second operand is bit-inverted and the carry into the lowest bit is forced high, so the adder performs a two's-complement subtraction.

The result reaches the shared bus only while the sum-out strobe is high; at other times the drive enable is low and the data lines are held at zero. Carry, zero and negative conditions of the current result are taken into a private three-bit flag register on a clock edge where the flag-load strobe is high, and they stay there until the next such edge. A compare is therefore just flag-load with subtract and without sum-out: the flags change while the accumulator is left alone. A synchronous reset clears the flags.

Top module: `acc_alu_flags`

## Requirements
- R1: With sub_en low and sum_out_en high, bus_data equals (a_val + b_val) modulo 2^W in the same cycle.
- R2: With sub_en high and sum_out_en high, bus_data equals (a_val - b_val) modulo 2^W in the same cycle, formed as a_val + ~b_val + 1.
- R3: bus_drive is high exactly while sum_out_en is high; while sum_out_en is low, bus_data is all zeros.
- R4: After a clock edge with flag_load high, carry_flag holds the carry out of the top adder bit for the operands at that edge; when subtracting it is 1 exactly when a_val >= b_val as unsigned numbers.
- R5: After a clock edge with flag_load high, zero_flag is 1 exactly when every bit of the result at that edge was 0.
- R6: After a clock edge with flag_load high, neg_flag equals bit W-1 of the result at that edge.
- R7: On a clock edge with flag_load low and rst low, all three flags keep their values, whatever a_val, b_val and sub_en do.
- R8: flag_load high with sum_out_en low updates the flags from the current result while bus_drive stays low and bus_data stays zero (a compare).
- R9: A clock edge with rst high clears all three flags, even when flag_load is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| a_val | input | W | Accumulator operand |
| b_val | input | W | Second operand |
| sub_en | input | 1 | 1 selects a_val - b_val, 0 selects a_val + b_val |
| sum_out_en | input | 1 | Place the result on the bus |
| flag_load | input | 1 | Capture flags on the next rising edge |
| bus_data | output | W | Result while driving, zero otherwise |
| bus_drive | output | 1 | Bus drive enable |
| carry_flag | output | 1 | Registered carry out of the top bit |
| zero_flag | output | 1 | Registered all-zero result |
| neg_flag | output | 1 | Registered top bit of the result |

## Verification
The result and bus enable are combinational, so they are due in the same cycle as the operands and strobes; the bench drives on the falling edge and samples them one nanosecond later, before the next rising edge. The flags are due one rising edge after flag_load is applied, so the bench applies stimulus on a falling edge and reads the flags on the following falling edge. Hold checks repeat that read after edges with flag_load low and changed operands, and the reset check applies flag_load together with reset to show reset takes priority.

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic         sub_en,
  input  logic         sum_out_en,
  input  logic         flag_load,
  output logic [W-1:0] bus_data,
  output logic         bus_drive,
  output logic         carry_flag,
  output logic         zero_flag,
  output logic         neg_flag
);

  localparam int MSB = W - 1;

  logic [W:0]   cy;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign cy[0] = sub_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i]  = b_val[i] ^ sub_en;
    assign sum[i]    = a_val[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (a_val[i] & b_eff[i]) | (cy[i] & (a_val[i] ^ b_eff[i]));
  end

  assign bus_drive = sum_out_en;
  assign bus_data  = sum_out_en ? sum : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_flag <= 1'b0;
      zero_flag  <= 1'b0;
      neg_flag   <= 1'b0;
    end else if (flag_load) begin
      carry_flag <= cy[W];
      zero_flag  <= ~|sum;
      neg_flag   <= sum[MSB];
    end
  end

endmodule

// File: rtl/acc_alu_flags_chk.sv
module acc_alu_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_val,
  input logic [W-1:0] b_val,
  input logic         sub_en,
  input logic         sum_out_en,
  input logic         flag_load,
  input logic [W-1:0] bus_data,
  input logic         bus_drive,
  input logic         carry_flag,
  input logic         zero_flag,
  input logic         neg_flag
);

  p_add_r1: assert property (@(posedge clk) disable iff (rst)
    (sum_out_en && !sub_en) |-> bus_data == W'(a_val + b_val));

  p_sub_r2: assert property (@(posedge clk) disable iff (rst)
    (sum_out_en && sub_en) |-> bus_data == W'(a_val - b_val));

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    !sum_out_en |-> (!bus_drive && bus_data == '0));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_load && sum_out_en) |=> zero_flag == ($past(bus_data) == '0));

  p_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_load && sum_out_en) |=> neg_flag == $past(bus_data[W-1]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !flag_load |=> $stable({carry_flag, zero_flag, neg_flag}));

  p_clear_r9: assert property (@(posedge clk)
    rst |=> (!carry_flag && !zero_flag && !neg_flag));

endmodule

bind acc_alu_flags acc_alu_flags_chk #(.W(W)) u_chk (.*);

// File: tb/acc_alu_flags_test.sv
module acc_alu_flags_test;
  localparam int W = 8;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_val, b_val;
  logic         sub_en, sum_out_en, flag_load;
  logic [W-1:0] bus_data;
  logic         bus_drive, carry_flag, zero_flag, neg_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu_flags #(.W(W)) uut (
    .clk(clk), .rst(rst), .a_val(a_val), .b_val(b_val), .sub_en(sub_en),
    .sum_out_en(sum_out_en), .flag_load(flag_load), .bus_data(bus_data),
    .bus_drive(bus_drive), .carry_flag(carry_flag), .zero_flag(zero_flag),
    .neg_flag(neg_flag)
  );

  // {a, b, sub, expected result, expected carry}
  localparam logic [25:0] VEC [NV] = '{
    {8'h03, 8'h05, 1'b0, 8'h08, 1'b0},
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0},
    {8'hC8, 8'h64, 1'b0, 8'h2C, 1'b1},
    {8'hFB, 8'h05, 1'b0, 8'h00, 1'b1},
    {8'h05, 8'h03, 1'b1, 8'h02, 1'b1},
    {8'h03, 8'h05, 1'b1, 8'hFE, 1'b0},
    {8'h2A, 8'h2A, 1'b1, 8'h00, 1'b1},
    {8'h00, 8'h01, 1'b1, 8'hFF, 1'b0},
    {8'h80, 8'h01, 1'b1, 8'h7F, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag, input logic c, input logic z, input logic n);
    check({carry_flag, zero_flag, neg_flag} == {c, z, n}, tag,
          {29'd0, carry_flag, zero_flag, neg_flag}, {29'd0, c, z, n});
  endtask

  initial begin
    #800000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; a_val = '0; b_val = '0; sub_en = 1'b0; sum_out_en = 1'b0; flag_load = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_flags("R9 reset state", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    #1;
    // R3 released bus
    check(!bus_drive && bus_data == '0, "R3 idle release", {23'd0, bus_drive, bus_data}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ea, eb, es;
      logic es_sub, ec;
      {ea, eb, es_sub, es, ec} = VEC[i];
      @(negedge clk);
      a_val = ea; b_val = eb; sub_en = es_sub; sum_out_en = 1'b1; flag_load = 1'b1;
      #1;
      check(bus_data == es && bus_drive, es_sub ? "R2 difference" : "R1 sum",
            {23'd0, bus_drive, bus_data}, {23'd1, es});
      @(negedge clk);
      check_flags("R4 R5 R6 flags", ec, es == 8'h00, es[7]);
    end

    // R7 hold: set flags from FF+01 then change operands without load
    a_val = 8'hFF; b_val = 8'h01; sub_en = 1'b0; sum_out_en = 1'b1; flag_load = 1'b1;
    @(negedge clk);
    flag_load = 1'b0; a_val = 8'h01; b_val = 8'h02; sub_en = 1'b1;
    @(negedge clk);
    check_flags("R7 hold after operand change", 1'b1, 1'b1, 1'b0);
    a_val = 8'h90; b_val = 8'h00; sub_en = 1'b0;
    @(negedge clk);
    check_flags("R7 hold second edge", 1'b1, 1'b1, 1'b0);

    // R8 compare: 0x10 - 0x20 without driving bus
    a_val = 8'h10; b_val = 8'h20; sub_en = 1'b1; sum_out_en = 1'b0; flag_load = 1'b1;
    #1;
    check(!bus_drive && bus_data == '0, "R8 compare bus idle", {23'd0, bus_drive, bus_data}, 32'd0);
    @(negedge clk);
    check_flags("R8 compare flags", 1'b0, 1'b0, 1'b1);
    a_val = 8'h33; b_val = 8'h33;
    @(negedge clk);
    check_flags("R8 R4 compare equal", 1'b1, 1'b1, 1'b0);

    // R9 reset wins over load
    a_val = 8'hFF; b_val = 8'h01; sub_en = 1'b0; flag_load = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_flags("R9 reset over load", 1'b0, 1'b0, 1'b0);
    rst = 1'b0; flag_load = 1'b0;
    @(negedge clk);
    check_flags("R9 stays clear", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule